// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block performs the hardware steps a 32-bit CPU takes when it enters an exception. It watches three kinds of reset event: a rising edge on the external reset pin, a watchdog overflow pulse, and a two-step command from the debug port. It also takes address-error, trap, illegal-instruction and interrupt requests from the decoder and the interrupt controller. Once it accepts an event, it runs a short sequence of word transfers on a simple request/ready memory bus. It then issues one-cycle write strobes for the new PC, R15, VBR and SR mask values, and a completion pulse tells the pipeline to resume.

A reset never touches the stack. It reads the starting PC and SP from two fixed addresses, clears VBR and raises all four mask bits. Every other exception first saves SR and then PC below the current R15. It then reads the handler address from the vector table at VBR plus four times the vector number. Only interrupt entry changes the mask, which takes the accepted priority level. The pipeline supplies the current PC, SR, R15 and VBR, and it keeps its register file up to date from the write strobes.

Top module: `exc_entry_seq`

## Requirements
- R1: A power-on reset sequence starts on a low-to-high transition of `reset_pin` or on a `wdt_ovf` pulse. Holding `reset_pin` high with no new transition starts nothing.
- R2: A debug reset starts only when a negate command (`dbg_cmd_valid` with `dbg_cmd_negate`=1) follows an assert command (`dbg_cmd_valid` with `dbg_cmd_negate`=0). A negate command with no prior assert is ignored.
- R3: A reset reads the PC from 0xA0000000 and then the SP from 0xA0000004, with no bus writes. It loads `pc_out` and `r15_out` with the two words read.
- R4: A reset writes 0x00000000 to VBR and 4'b1111 to the mask bits, in the same cycle as the PC write.
- R5: A non-reset exception is accepted only while the block is idle and `insn_done` is high. Requests made while `insn_done` is low are ignored.
- R6: A non-reset exception first writes SR to R15-4 and then PC to R15-8, and it finishes with `r15_out` = R15-8.
- R7: The handler PC is read from VBR + 4*vector. The vectors are 9 for an address error, 4 for a general illegal instruction, 6 for an illegal slot instruction, `trap_vec` for a trap and `irq_vec` for an interrupt.
- R8: An undefined code with `in_slot`=1, or a PC-changing instruction with `in_slot`=1, is an illegal slot exception. An undefined code with `in_slot`=0 is a general illegal exception. A PC-changing instruction with `in_slot`=0 raises nothing.
- R9: Interrupt entry writes `irq_level` to the mask bits. Address-error and instruction exceptions give no mask write.
- R10: When several events arrive together, the order is reset, then address error, then illegal slot, then general illegal, then trap, then interrupt. Requests that lose are dropped.
- R11: A bus request keeps its address, direction and write data unchanged until `bus_ready` is seen high.
- R12: `pc_we` is high for one cycle, and `done` is high for exactly the one cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| reset_pin | input | 1 | External reset pin level |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| dbg_cmd_valid | input | 1 | Debug-port reset command strobe |
| dbg_cmd_negate | input | 1 | 0 = reset-assert command, 1 = reset-negate command |
| insn_done | input | 1 | Current instruction has completed |
| addr_err | input | 1 | Address error flagged by decode |
| undef_code | input | 1 | Undefined instruction code decoded |
| pc_change | input | 1 | Decoded instruction changes the PC |
| in_slot | input | 1 | Decoded instruction sits in a delay slot |
| trap_req | input | 1 | Trap instruction executed |
| trap_vec | input | 8 | Trap vector number |
| irq_req | input | 1 | Interrupt request accepted by the controller |
| irq_level | input | 4 | Priority level of the interrupt |
| irq_vec | input | 8 | Interrupt vector number |
| cur_pc | input | 32 | PC value to save |
| cur_sr | input | 32 | SR value to save |
| cur_r15 | input | 32 | Current stack pointer |
| cur_vbr | input | 32 | Current vector base |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer completes at this edge |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| pc_out | output | 32 | New PC |
| pc_we | output | 1 | PC write strobe |
| r15_out | output | 32 | New R15 |
| r15_we | output | 1 | R15 write strobe |
| vbr_out | output | 32 | New VBR |
| vbr_we | output | 1 | VBR write strobe |
| mask_out | output | 4 | New SR mask bits |
| mask_we | output | 1 | Mask write strobe |
| done | output | 1 | Entry complete, pipeline may resume |

## Verification
The assertions check four things on every cycle: bus requests stay stable while they wait, each PC write is followed by exactly one completion pulse, a reset always loads VBR and the mask together with the PC, and every push starts at R15-4 with SR data and only after a completed instruction. Other behaviour shows only in the bench scenarios. These are the rule that the debug port needs an assert before a negate, the priority among events that arrive together, the split between delay-slot and general illegal codes, the vector table addresses, and the absence of a mask write for exceptions other than interrupts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RPC, ST_RSP, ST_PSR, ST_PPC, ST_VEC, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    EK_NONE, EK_ADDR, EK_SLOT, EK_GEN, EK_TRAP, EK_IRQ
  } exc_kind_e;
endpackage

// File: rtl/exc_reset_detect.sv
module exc_reset_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic wdt_ovf,
  input  logic dbg_valid,
  input  logic dbg_negate,
  output logic event_now
);
  logic pin_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b1;
      armed <= 1'b0;
    end else begin
      pin_q <= pin;
      if (dbg_valid) armed <= ~dbg_negate;
    end
  end

  // pin edge, watchdog pulse, or negate following an assert
  assign event_now = (pin & ~pin_q) | wdt_ovf | (dbg_valid & dbg_negate & armed);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int VEC_ADDR_ERR = 9,
  parameter int VEC_SLOT     = 6,
  parameter int VEC_GEN      = 4
) (
  input  logic             insn_done,
  input  logic             addr_err,
  input  logic             undef_code,
  input  logic             pc_change,
  input  logic             in_slot,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             take,
  output exc_kind_e        kind,
  output logic [VEC_W-1:0] vec
);
  logic slot_ill;
  logic gen_ill;

  assign slot_ill = in_slot & (undef_code | pc_change);
  assign gen_ill  = undef_code & ~in_slot;

  always_comb begin
    kind = EK_NONE;
    vec  = '0;
    if (addr_err) begin
      kind = EK_ADDR;
      vec  = VEC_W'(VEC_ADDR_ERR);
    end else if (slot_ill) begin
      kind = EK_SLOT;
      vec  = VEC_W'(VEC_SLOT);
    end else if (gen_ill) begin
      kind = EK_GEN;
      vec  = VEC_W'(VEC_GEN);
    end else if (trap_req) begin
      kind = EK_TRAP;
      vec  = trap_vec;
    end else if (irq_req) begin
      kind = EK_IRQ;
      vec  = irq_vec;
    end
  end

  assign take = insn_done & (kind != EK_NONE);
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          VEC_W       = 8,
  parameter int          MASK_W      = 4,
  parameter logic [31:0] RST_PC_ADDR = 32'hA000_0000,
  parameter logic [31:0] RST_SP_ADDR = 32'hA000_0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_event,
  input  logic              exc_take,
  input  exc_kind_e         exc_kind,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic [MASK_W-1:0] irq_level,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   cur_vbr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [XLEN-1:0]   bus_addr,
  output logic [XLEN-1:0]   bus_wdata,
  input  logic              bus_ready,
  input  logic [XLEN-1:0]   bus_rdata,
  output logic [XLEN-1:0]   pc_out,
  output logic              pc_we,
  output logic [XLEN-1:0]   r15_out,
  output logic              r15_we,
  output logic [XLEN-1:0]   vbr_out,
  output logic              vbr_we,
  output logic [MASK_W-1:0] mask_out,
  output logic              mask_we,
  output logic              done
);
  localparam int          WORD_BYTES = XLEN / 8;
  localparam int          VEC_SHIFT  = $clog2(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP1  = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP2  = XLEN'(2 * WORD_BYTES);

  seq_state_e        state;
  logic              rst_pend;
  logic              rst_go;
  exc_kind_e         kind_q;
  logic [VEC_W-1:0]  vec_q;
  logic [MASK_W-1:0] lvl_q;
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   r15_q;
  logic [XLEN-1:0]   vbr_q;
  logic [XLEN-1:0]   vec_addr;

  assign rst_go   = rst_pend | rst_event;
  assign vec_addr = vbr_q + (XLEN'(vec_q) << VEC_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend <= 1'b0;
    end else if (state == ST_IDLE && rst_go) begin
      rst_pend <= 1'b0;
    end else if (rst_event) begin
      rst_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      pc_out    <= '0;
      r15_out   <= '0;
      vbr_out   <= '0;
      mask_out  <= '1;
      pc_we     <= 1'b0;
      r15_we    <= 1'b0;
      vbr_we    <= 1'b0;
      mask_we   <= 1'b0;
      done      <= 1'b0;
      kind_q    <= EK_NONE;
      vec_q     <= '0;
      lvl_q     <= '0;
      pc_q      <= '0;
      r15_q     <= '0;
      vbr_q     <= '0;
    end else begin
      pc_we   <= 1'b0;
      r15_we  <= 1'b0;
      vbr_we  <= 1'b0;
      mask_we <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rst_go) begin
            state    <= ST_RPC;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= XLEN'(RST_PC_ADDR);
          end else if (exc_take) begin
            state     <= ST_PSR;
            kind_q    <= exc_kind;
            vec_q     <= exc_vec;
            lvl_q     <= irq_level;
            pc_q      <= cur_pc;
            r15_q     <= cur_r15;
            vbr_q     <= cur_vbr;
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= cur_r15 - STEP1;
            bus_wdata <= cur_sr;
          end
        end
        ST_RPC: begin
          if (bus_ready) begin
            pc_out   <= bus_rdata;
            bus_addr <= XLEN'(RST_SP_ADDR);
            state    <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (bus_ready) begin
            r15_out  <= bus_rdata;
            vbr_out  <= '0;
            mask_out <= '1;
            pc_we    <= 1'b1;
            r15_we   <= 1'b1;
            vbr_we   <= 1'b1;
            mask_we  <= 1'b1;
            bus_req  <= 1'b0;
            state    <= ST_DONE;
          end
        end
        ST_PSR: begin
          if (bus_ready) begin
            bus_addr  <= r15_q - STEP2;
            bus_wdata <= pc_q;
            state     <= ST_PPC;
          end
        end
        ST_PPC: begin
          if (bus_ready) begin
            bus_we    <= 1'b0;
            bus_wdata <= '0;
            bus_addr  <= vec_addr;
            state     <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (bus_ready) begin
            pc_out  <= bus_rdata;
            r15_out <= r15_q - STEP2;
            pc_we   <= 1'b1;
            r15_we  <= 1'b1;
            if (kind_q == EK_IRQ) begin
              mask_out <= lvl_q;
              mask_we  <= 1'b1;
            end
            bus_req <= 1'b0;
            state   <= ST_DONE;
          end
        end
        ST_DONE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          VEC_W        = 8,
  parameter int          MASK_W       = 4,
  parameter int          VEC_ADDR_ERR = 9,
  parameter int          VEC_SLOT     = 6,
  parameter int          VEC_GEN      = 4,
  parameter logic [31:0] RST_PC_ADDR  = 32'hA000_0000,
  parameter logic [31:0] RST_SP_ADDR  = 32'hA000_0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_pin,
  input  logic              wdt_ovf,
  input  logic              dbg_cmd_valid,
  input  logic              dbg_cmd_negate,
  input  logic              insn_done,
  input  logic              addr_err,
  input  logic              undef_code,
  input  logic              pc_change,
  input  logic              in_slot,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              irq_req,
  input  logic [MASK_W-1:0] irq_level,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   cur_vbr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [XLEN-1:0]   bus_addr,
  output logic [XLEN-1:0]   bus_wdata,
  input  logic              bus_ready,
  input  logic [XLEN-1:0]   bus_rdata,
  output logic [XLEN-1:0]   pc_out,
  output logic              pc_we,
  output logic [XLEN-1:0]   r15_out,
  output logic              r15_we,
  output logic [XLEN-1:0]   vbr_out,
  output logic              vbr_we,
  output logic [MASK_W-1:0] mask_out,
  output logic              mask_we,
  output logic              done
);
  logic             rst_event;
  logic             exc_take;
  exc_kind_e        exc_kind;
  logic [VEC_W-1:0] exc_vec;

  exc_reset_detect u_rstdet (
    .clk        (clk),
    .rst        (rst),
    .pin        (reset_pin),
    .wdt_ovf    (wdt_ovf),
    .dbg_valid  (dbg_cmd_valid),
    .dbg_negate (dbg_cmd_negate),
    .event_now  (rst_event)
  );

  exc_arbiter #(
    .VEC_W        (VEC_W),
    .VEC_ADDR_ERR (VEC_ADDR_ERR),
    .VEC_SLOT     (VEC_SLOT),
    .VEC_GEN      (VEC_GEN)
  ) u_arb (
    .insn_done  (insn_done),
    .addr_err   (addr_err),
    .undef_code (undef_code),
    .pc_change  (pc_change),
    .in_slot    (in_slot),
    .trap_req   (trap_req),
    .trap_vec   (trap_vec),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .take       (exc_take),
    .kind       (exc_kind),
    .vec        (exc_vec)
  );

  exc_seq_fsm #(
    .XLEN        (XLEN),
    .VEC_W       (VEC_W),
    .MASK_W      (MASK_W),
    .RST_PC_ADDR (RST_PC_ADDR),
    .RST_SP_ADDR (RST_SP_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rst_event (rst_event),
    .exc_take  (exc_take),
    .exc_kind  (exc_kind),
    .exc_vec   (exc_vec),
    .irq_level (irq_level),
    .cur_pc    (cur_pc),
    .cur_sr    (cur_sr),
    .cur_r15   (cur_r15),
    .cur_vbr   (cur_vbr),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .pc_out    (pc_out),
    .pc_we     (pc_we),
    .r15_out   (r15_out),
    .r15_we    (r15_we),
    .vbr_out   (vbr_out),
    .vbr_we    (vbr_we),
    .mask_out  (mask_out),
    .mask_we   (mask_we),
    .done      (done)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_done,
  input logic [XLEN-1:0]   cur_sr,
  input logic [XLEN-1:0]   cur_r15,
  input logic              bus_req,
  input logic              bus_we,
  input logic [XLEN-1:0]   bus_addr,
  input logic [XLEN-1:0]   bus_wdata,
  input logic              bus_ready,
  input logic              pc_we,
  input logic              vbr_we,
  input logic [XLEN-1:0]   vbr_out,
  input logic [MASK_W-1:0] mask_out,
  input logic              mask_we,
  input logic              done
);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(XLEN / 8);

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_done_follows_pc_R12: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> done);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !pc_we));

  assert_reset_loads_R4: assert property (@(posedge clk) disable iff (rst)
    vbr_we |-> (vbr_out == '0 && mask_out == '1 && mask_we && pc_we));

  assert_push_after_insn_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_we) |-> $past(insn_done));

  assert_first_push_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_we) |-> (bus_addr == $past(cur_r15) - STEP1 && bus_wdata == $past(cur_sr)));

  assert_mask_with_pc_R9: assert property (@(posedge clk) disable iff (rst)
    mask_we |-> pc_we);
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn_done (insn_done),
  .cur_sr    (cur_sr),
  .cur_r15   (cur_r15),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .pc_we     (pc_we),
  .vbr_we    (vbr_we),
  .vbr_out   (vbr_out),
  .mask_out  (mask_out),
  .mask_we   (mask_we),
  .done      (done)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV_PC = 32'h0000_1000;
  localparam logic [31:0] RV_SP = 32'h0FFF_FFF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reset_pin = 1'b1, wdt_ovf = 1'b0, dbg_cmd_valid = 1'b0, dbg_cmd_negate = 1'b0;
  logic insn_done = 1'b0, addr_err = 1'b0, undef_code = 1'b0, pc_change = 1'b0, in_slot = 1'b0;
  logic trap_req = 1'b0, irq_req = 1'b0;
  logic [7:0] trap_vec = '0, irq_vec = '0;
  logic [3:0] irq_level = '0;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, cur_vbr = '0;
  logic bus_req, bus_we, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [31:0] pc_out, r15_out, vbr_out;
  logic pc_we, r15_we, vbr_we, mask_we, done;
  logic [3:0] mask_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bus log and output monitor
  bit          l_we[8];
  logic [31:0] l_addr[8];
  logic [31:0] l_data[8];
  int          l_cnt;
  logic [31:0] m_pc, m_r15, m_vbr;
  logic [3:0]  m_mask;
  bit          m_pc_seen, m_vbr_seen, m_mask_seen;
  int          m_done_cnt;
  int          wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst(rst), .reset_pin(reset_pin), .wdt_ovf(wdt_ovf),
    .dbg_cmd_valid(dbg_cmd_valid), .dbg_cmd_negate(dbg_cmd_negate),
    .insn_done(insn_done), .addr_err(addr_err), .undef_code(undef_code),
    .pc_change(pc_change), .in_slot(in_slot), .trap_req(trap_req), .trap_vec(trap_vec),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15), .cur_vbr(cur_vbr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .pc_out(pc_out), .pc_we(pc_we), .r15_out(r15_out), .r15_we(r15_we),
    .vbr_out(vbr_out), .vbr_we(vbr_we), .mask_out(mask_out), .mask_we(mask_we), .done(done)
  );

  function automatic logic [31:0] memval(input logic [31:0] a);
    if (a == 32'hA000_0000) return RV_PC;
    if (a == 32'hA000_0004) return RV_SP;
    return (a * 32'h9E37_79B1) ^ 32'h0000_1234;
  endfunction

  // expected vector (-1 when nothing is raised), R7 R8 R10
  function automatic int exp_vec(input bit a, u, p, s, t, i, input logic [7:0] tv, iv);
    if (a) return 9;
    if (s && (u || p)) return 6;
    if (u) return 4;
    if (t) return int'(tv);
    if (i) return int'(iv);
    return -1;
  endfunction

  function automatic bit exp_irq(input bit a, u, p, s, t, i);
    return !a && !(s && (u || p)) && !u && !t && i;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic clear_log();
    l_cnt = 0; m_pc_seen = 0; m_vbr_seen = 0; m_mask_seen = 0; m_done_cnt = 0;
  endtask

  // bus slave: random wait states, logs each transfer as it is granted
  initial begin
    bus_ready = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_ready) bus_ready = 1'b0;
      else if (bus_req) begin
        if (wait_cnt == 0) begin
          bus_ready = 1'b1;
          bus_rdata = bus_we ? 32'h0 : memval(bus_addr);
          if (l_cnt < 8) begin
            l_we[l_cnt] = bus_we; l_addr[l_cnt] = bus_addr; l_data[l_cnt] = bus_wdata;
          end
          l_cnt++;
          wait_cnt = int'($urandom_range(0, 2));
        end else wait_cnt--;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pc_we) begin m_pc = pc_out; m_pc_seen = 1; m_r15 = r15_out; end
      if (vbr_we) begin m_vbr = vbr_out; m_vbr_seen = 1; end
      if (mask_we) begin m_mask = mask_out; m_mask_seen = 1; end
      if (done) m_done_cnt++;
    end
  end

  task automatic wait_done(input string rq);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done, rq, 32'(n), 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_idle(input string rq);
    repeat (20) @(negedge clk);
    chk(l_cnt == 0 && m_done_cnt == 0, rq, 32'(l_cnt + m_done_cnt), 32'd0);
  endtask

  task automatic check_reset_seq(input string rq);
    wait_done(rq);
    chk(l_cnt == 2, "R3 transfer count", 32'(l_cnt), 32'd2);
    chk(!l_we[0] && l_addr[0] == 32'hA000_0000, "R3 first read", l_addr[0], 32'hA000_0000);
    chk(!l_we[1] && l_addr[1] == 32'hA000_0004, "R3 second read", l_addr[1], 32'hA000_0004);
    chk(m_pc_seen && m_pc == RV_PC, "R3 pc", m_pc, RV_PC);
    chk(m_r15 == RV_SP, "R3 sp", m_r15, RV_SP);
    chk(m_vbr_seen && m_vbr == 32'h0, "R4 vbr", m_vbr, 32'h0);
    chk(m_mask_seen && m_mask == 4'hF, "R4 mask", 32'(m_mask), 32'hF);
    chk(m_done_cnt == 1, "R12 single done", 32'(m_done_cnt), 32'd1);
  endtask

  task automatic run_exc(input bit a, u, p, s, t, i, input logic [7:0] tv, iv, input logic [3:0] lvl);
    int v;
    logic [31:0] r15, sr, pc, vbr, va;
    v = exp_vec(a, u, p, s, t, i, tv, iv);
    r15 = ($urandom & 32'h0FFF_FFFC) | 32'h1000_0000;
    sr  = $urandom; pc = $urandom & 32'hFFFF_FFFE; vbr = $urandom & 32'h0FFF_FC00;
    clear_log();
    @(negedge clk);
    cur_r15 = r15; cur_sr = sr; cur_pc = pc; cur_vbr = vbr;
    addr_err = a; undef_code = u; pc_change = p; in_slot = s; trap_req = t; irq_req = i;
    trap_vec = tv; irq_vec = iv; irq_level = lvl; insn_done = 1'b1;
    @(negedge clk);
    addr_err = 0; undef_code = 0; pc_change = 0; in_slot = 0; trap_req = 0; irq_req = 0; insn_done = 0;
    if (v < 0) begin
      expect_idle("R8 nothing raised");
      return;
    end
    va = vbr + 32'(v) * 4;
    wait_done("R12 entry completes");
    chk(l_cnt == 3, "R6 transfer count", 32'(l_cnt), 32'd3);
    chk(l_we[0] && l_addr[0] == r15 - 4 && l_data[0] == sr, "R6 SR push", l_addr[0], r15 - 4);
    chk(l_we[1] && l_addr[1] == r15 - 8 && l_data[1] == pc, "R6 PC push", l_addr[1], r15 - 8);
    chk(!l_we[2] && l_addr[2] == va, "R7 R10 vector address", l_addr[2], va);
    chk(m_pc_seen && m_pc == memval(va), "R7 handler pc", m_pc, memval(va));
    chk(m_r15 == r15 - 8, "R6 final r15", m_r15, r15 - 8);
    chk(!m_vbr_seen, "R4 no vbr write", 32'(m_vbr_seen), 32'd0);
    if (exp_irq(a, u, p, s, t, i))
      chk(m_mask_seen && m_mask == lvl, "R9 irq mask", 32'(m_mask), 32'(lvl));
    else
      chk(!m_mask_seen, "R9 mask untouched", 32'(m_mask_seen), 32'd0);
  endtask

  initial begin
    repeat (1000 * 150) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7606));
    clear_log();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !done && !pc_we, "R12 reset state", {29'd0, bus_req, done, pc_we}, 32'd0);

    // R1: pin held high, no edge
    expect_idle("R1 level without edge");
    // R1: rising edge of the pin
    clear_log();
    reset_pin = 1'b0; @(negedge clk); reset_pin = 1'b1;
    check_reset_seq("R1 pin edge");
    // R1: watchdog pulse
    clear_log();
    wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
    check_reset_seq("R1 watchdog");

    // R2: negate alone is ignored
    clear_log();
    dbg_cmd_valid = 1; dbg_cmd_negate = 1; @(negedge clk); dbg_cmd_valid = 0;
    expect_idle("R2 negate alone");
    // R2: assert then negate
    clear_log();
    dbg_cmd_valid = 1; dbg_cmd_negate = 0; @(negedge clk);
    dbg_cmd_negate = 1; @(negedge clk); dbg_cmd_valid = 0; dbg_cmd_negate = 0;
    check_reset_seq("R2 debug sequence");

    // R5: request without completed instruction
    clear_log();
    addr_err = 1; trap_req = 1; @(negedge clk); addr_err = 0; trap_req = 0;
    expect_idle("R5 insn_done low");

    // R10: reset beats a simultaneous address error
    clear_log();
    wdt_ovf = 1; addr_err = 1; insn_done = 1; @(negedge clk);
    wdt_ovf = 0; addr_err = 0; insn_done = 0;
    check_reset_seq("R10 reset first");

    // directed kinds
    run_exc(1, 0, 0, 0, 0, 0, 8'h20, 8'h40, 4'h3); // R7 address error
    run_exc(0, 1, 0, 0, 0, 0, 8'h20, 8'h40, 4'h3); // R8 general illegal
    run_exc(0, 1, 0, 1, 0, 0, 8'h20, 8'h40, 4'h3); // R8 undefined in slot
    run_exc(0, 0, 1, 1, 0, 0, 8'h20, 8'h40, 4'h3); // R8 branch in slot
    run_exc(0, 0, 1, 0, 0, 0, 8'h20, 8'h40, 4'h3); // R8 branch outside slot
    run_exc(0, 0, 0, 0, 1, 0, 8'hFF, 8'h40, 4'h3); // R7 trap, top vector
    run_exc(0, 0, 0, 0, 0, 1, 8'h20, 8'h00, 4'hD); // R9 interrupt
    run_exc(1, 0, 0, 0, 1, 1, 8'h21, 8'h41, 4'h7); // R10 address error first
    run_exc(0, 0, 0, 0, 1, 1, 8'h22, 8'h42, 4'h7); // R10 trap over irq
    run_exc(0, 1, 0, 1, 1, 1, 8'h23, 8'h43, 4'h7); // R10 slot over trap

    // random mix
    for (int k = 0; k < 80; k++) begin
      run_exc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
              $urandom_range(0, 1) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0,
              8'($urandom), 8'($urandom), 4'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule